// File: doc/BRIEF.md
# Valid/Ready Stream Crossbar Switch

This block connects a set of producer streams to a set of consumer streams. Each producer offers a payload, a valid bit and a select field that names the consumer it wants. Each consumer has its own round-robin arbiter, which chooses among the producers aimed at it. The consumer side shows the chosen payload together with the binary index of the producer it came from. Every port pair follows valid/ready rules. A transfer happens on a rising clock edge where valid and ready are both high. A producer that has raised valid keeps valid, payload and select unchanged until it sees ready. A consumer may hold ready low for as long as it likes, and that back-pressure reaches only the producer that currently wins that consumer.

Build-time options set the behaviour. Lock-in keeps an arbitration choice until its transfer completes, so a stalled consumer output never changes. External priority replaces each arbiter's rotating pointer with a start index driven from outside. An optional two-entry output stage on every consumer port removes the combinational path from consumer ready to producer ready. The flush pin returns all arbiters to their reset state. It may only be raised while no producer valid is high. Reset is asynchronous and active low, and the clock is rising-edge.

Top module: `xbar_stream_switch`

## Requirements
- R1: After reset every arbiter pointer is at producer 0, so with all producers requesting one consumer the first grant goes to producer 0. With the output stage built in, every consumer valid is low after reset.
- R2: Without the output stage, consumer j shows valid in the same cycle that at least one producer has valid high with a select value equal to j. Its payload and index are those of the granted producer.
- R3: An arbiter grants the first requesting producer found at or after its pointer, counting upward and wrapping from NumIn-1 to 0. After a completed transfer on consumer j, only that arbiter's pointer moves, to the producer just after the winner.
- R4: Without the output stage, a producer's ready is high exactly when it wins the consumer it selects and that consumer's ready is high.
- R5: With lock-in, once consumer j shows valid with ready low, the same producer stays granted until the transfer completes. This holds even when a producer nearer the pointer starts to request.
- R6: With lock-in and rule-abiding producers, a consumer that shows valid with ready low keeps valid, payload and index unchanged in the next cycle.
- R7: A one-cycle flush returns every pointer to producer 0 and drops any held grant.
- R8: With external priority, the search of consumer j starts at the producer index on its priority input. Completed transfers do not move that start point.
- R9: With the output stage, a granted item appears on the consumer one cycle after it is accepted. Producer ready depends only on stage occupancy, not on consumer ready. A stalled consumer absorbs two items before producer ready falls.
- R10: The select field is ceil(log2(NumOut)) bits wide, with a minimum of one bit, and holds a binary consumer number. A producer with valid high and a select value of NumOut or more is never granted, never sees ready, and makes no consumer valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Clears all arbiter state; only while no producer valid is high |
| prio_i | input | NumOut x IdxW | Per-consumer search start when external priority is built in, otherwise tie to zero |
| in_data_i | input | NumIn x DataW | Producer payloads |
| in_sel_i | input | NumIn x SelW | Producer target consumer number |
| in_valid_i | input | NumIn | Producer valid |
| in_ready_o | output | NumIn | Producer ready |
| out_data_o | output | NumOut x DataW | Consumer payloads |
| out_src_o | output | NumOut x IdxW | Index of the producer each payload came from |
| out_valid_o | output | NumOut | Consumer valid |
| out_ready_i | input | NumOut | Consumer ready |

## Verification
The bound checker watches four things on every cycle. In the unstaged build, each consumer valid must trace back to a live producer aimed at that consumer, and each producer ready must coincide with a taken transfer at its target. A stalled consumer must stay stable. An out-of-range select must never get ready. Round-robin order, pointer movement, lock-in against a new requester, flush, the fixed start of external priority, and the one-cycle latency and two-deep absorption of the output stage all depend on history. The bench shows these through directed sequences, plus a long pseudo-random run compared against its own arbitration model.

// File: rtl/xbar_sw_pkg.sv
package xbar_sw_pkg;

  // Width of a binary index over n items, never below one bit.
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/xbar_rr_pick.sv
module xbar_rr_pick
  import xbar_sw_pkg::*;
#(
  parameter int unsigned NumReq  = 4,
  parameter bit          LockIn  = 1'b1,
  parameter bit          ExtPrio = 1'b0,
  localparam int unsigned IdxW   = idx_bits(NumReq)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [NumReq-1:0] req_i,
  input  logic [IdxW-1:0]   prio_i,
  input  logic              take_i,
  output logic [NumReq-1:0] gnt_o,
  output logic [IdxW-1:0]   win_o,
  output logic              any_o
);

  logic [IdxW-1:0] ptr_q, hold_idx_q, start, pick, win;
  logic            hold_q, held, found;
  int unsigned     cand;

  // Cyclic search for the first requester at or after the start index.
  always_comb begin
    start = ExtPrio ? prio_i : ptr_q;
    pick  = '0;
    found = 1'b0;
    cand  = 0;
    for (int unsigned k = 0; k < NumReq; k++) begin
      cand = (32'(start) + k) % NumReq;
      if (!found && req_i[cand]) begin
        found = 1'b1;
        pick  = IdxW'(cand);
      end
    end
  end

  assign held  = LockIn && hold_q && req_i[hold_idx_q];
  assign win   = held ? hold_idx_q : pick;
  assign any_o = |req_i;
  assign win_o = win;
  assign gnt_o = any_o ? (NumReq'(1) << win) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q      <= '0;
      hold_q     <= 1'b0;
      hold_idx_q <= '0;
    end else if (flush_i) begin
      ptr_q      <= '0;
      hold_q     <= 1'b0;
      hold_idx_q <= '0;
    end else if (any_o && take_i) begin
      ptr_q  <= (32'(win) == NumReq - 1) ? '0 : win + IdxW'(1);
      hold_q <= 1'b0;
    end else begin
      hold_q     <= any_o && LockIn;
      hold_idx_q <= win;
    end
  end

endmodule

// File: rtl/xbar_spill_slot.sv
module xbar_spill_slot #(
  parameter int unsigned Width = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [Width-1:0] in_data_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [Width-1:0] out_data_o
);

  logic             a_full, b_full;
  logic [Width-1:0] a_q, b_q;
  logic             a_fill, a_drain, b_fill, b_drain;

  // Ready comes only from occupancy, never from out_ready_i.
  assign in_ready_o  = !a_full || !b_full;
  assign a_fill      = in_valid_i && in_ready_o;
  assign a_drain     = a_full && !b_full;
  assign b_fill      = a_drain && !out_ready_i;
  assign b_drain     = b_full && out_ready_i;
  assign out_valid_o = a_full || b_full;
  assign out_data_o  = b_full ? b_q : a_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_full <= 1'b0;
      a_q    <= '0;
    end else if (a_fill) begin
      a_full <= 1'b1;
      a_q    <= in_data_i;
    end else if (a_drain) begin
      a_full <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_full <= 1'b0;
      b_q    <= '0;
    end else if (b_fill) begin
      b_full <= 1'b1;
      b_q    <= a_q;
    end else if (b_drain) begin
      b_full <= 1'b0;
    end
  end

endmodule

// File: rtl/xbar_stream_switch.sv
module xbar_stream_switch
  import xbar_sw_pkg::*;
#(
  parameter int unsigned NumIn   = 4,
  parameter int unsigned NumOut  = 3,
  parameter int unsigned DataW   = 8,
  parameter bit          Spill   = 1'b0,
  parameter bit          ExtPrio = 1'b0,
  parameter bit          LockIn  = 1'b1,
  localparam int unsigned SelW   = idx_bits(NumOut),
  localparam int unsigned IdxW   = idx_bits(NumIn)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic [NumOut-1:0][IdxW-1:0]  prio_i,
  input  logic [NumIn-1:0][DataW-1:0]  in_data_i,
  input  logic [NumIn-1:0][SelW-1:0]   in_sel_i,
  input  logic [NumIn-1:0]             in_valid_i,
  output logic [NumIn-1:0]             in_ready_o,
  output logic [NumOut-1:0][DataW-1:0] out_data_o,
  output logic [NumOut-1:0][IdxW-1:0]  out_src_o,
  output logic [NumOut-1:0]            out_valid_o,
  input  logic [NumOut-1:0]            out_ready_i
);

  localparam int unsigned SlotW = IdxW + DataW;

  logic [NumOut-1:0][NumIn-1:0] req, gnt;
  logic [NumOut-1:0][IdxW-1:0]  win;
  logic [NumOut-1:0]            any, stage_rdy;
  logic [NumOut-1:0][SlotW-1:0] cand, slot;

  // Request matrix: producer i asks for consumer j.
  always_comb begin
    for (int j = 0; j < int'(NumOut); j++) begin
      for (int i = 0; i < int'(NumIn); i++) begin
        req[j][i] = in_valid_i[i] && (32'(in_sel_i[i]) == 32'(j));
      end
    end
  end

  for (genvar j = 0; j < NumOut; j++) begin : g_port
    xbar_rr_pick #(
      .NumReq  (NumIn),
      .LockIn  (LockIn),
      .ExtPrio (ExtPrio)
    ) i_pick (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (flush_i),
      .req_i   (req[j]),
      .prio_i  (prio_i[j]),
      .take_i  (stage_rdy[j]),
      .gnt_o   (gnt[j]),
      .win_o   (win[j]),
      .any_o   (any[j])
    );

    assign cand[j] = {win[j], in_data_i[win[j]]};

    if (Spill) begin : g_stage
      xbar_spill_slot #(
        .Width (SlotW)
      ) i_slot (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .in_valid_i  (any[j]),
        .in_ready_o  (stage_rdy[j]),
        .in_data_i   (cand[j]),
        .out_valid_o (out_valid_o[j]),
        .out_ready_i (out_ready_i[j]),
        .out_data_o  (slot[j])
      );
    end else begin : g_direct
      assign out_valid_o[j] = any[j];
      assign stage_rdy[j]   = out_ready_i[j];
      assign slot[j]        = cand[j];
    end

    assign out_src_o[j]  = slot[j][SlotW-1 -: IdxW];
    assign out_data_o[j] = slot[j][DataW-1:0];
  end

  // A producer is ready when its arbiter grants it and the port can take.
  always_comb begin
    in_ready_o = '0;
    for (int j = 0; j < int'(NumOut); j++) begin
      for (int i = 0; i < int'(NumIn); i++) begin
        if (gnt[j][i] && stage_rdy[j]) in_ready_o[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/xbar_stream_switch_chk.sv
module xbar_stream_switch_chk
  import xbar_sw_pkg::*;
#(
  parameter int unsigned NumIn  = 4,
  parameter int unsigned NumOut = 3,
  parameter int unsigned DataW  = 8,
  parameter bit          Spill  = 1'b0,
  parameter bit          LockIn = 1'b1,
  localparam int unsigned SelW  = idx_bits(NumOut),
  localparam int unsigned IdxW  = idx_bits(NumIn)
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [NumIn-1:0][SelW-1:0]   in_sel_i,
  input logic [NumIn-1:0]             in_valid_i,
  input logic [NumIn-1:0]             in_ready_o,
  input logic [NumOut-1:0][DataW-1:0] out_data_o,
  input logic [NumOut-1:0][IdxW-1:0]  out_src_o,
  input logic [NumOut-1:0]            out_valid_o,
  input logic [NumOut-1:0]            out_ready_i
);

  for (genvar j = 0; j < NumOut; j++) begin : g_out
    if (!Spill) begin : g_src
      AST_SRC_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o[j] |-> in_valid_i[out_src_o[j]] && (32'(in_sel_i[out_src_o[j]]) == 32'(j))); // R2
    end
    if (LockIn) begin : g_hold
      AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o[j] && !out_ready_i[j] |=> out_valid_o[j] && $stable(out_data_o[j]) && $stable(out_src_o[j])); // R6
    end
  end

  for (genvar i = 0; i < NumIn; i++) begin : g_in
    AST_BAD_SEL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i[i] && (32'(in_sel_i[i]) >= NumOut) |-> !in_ready_o[i]); // R10
    if (!Spill) begin : g_take
      AST_READY_MEANS_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i[i] && in_ready_o[i] |-> out_valid_o[in_sel_i[i]] && out_ready_i[in_sel_i[i]] && (out_src_o[in_sel_i[i]] == IdxW'(i))); // R4
    end
  end

endmodule

bind xbar_stream_switch xbar_stream_switch_chk #(
  .NumIn  (NumIn),
  .NumOut (NumOut),
  .DataW  (DataW),
  .Spill  (Spill),
  .LockIn (LockIn)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_sel_i    (in_sel_i),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_data_o  (out_data_o),
  .out_src_o   (out_src_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i)
);

// File: tb/test_xbar_stream_switch.sv
module test_xbar_stream_switch;

  localparam int CLK_P = 10;
  localparam int N = 4;
  localparam int M = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // Instance A: defaults (no stage, internal round robin, lock-in)
  logic             a_flush;
  logic [M-1:0][1:0] a_prio;
  logic [N-1:0][7:0] a_data;
  logic [N-1:0][1:0] a_sel;
  logic [N-1:0]      a_valid, a_iready;
  logic [M-1:0][7:0] a_odata;
  logic [M-1:0][1:0] a_osrc;
  logic [M-1:0]      a_ovalid, a_oready;

  // Instance B: output stage plus external priority
  logic [M-1:0][1:0] b_prio;
  logic [N-1:0][7:0] b_data;
  logic [N-1:0][1:0] b_sel;
  logic [N-1:0]      b_valid, b_iready;
  logic [M-1:0][7:0] b_odata;
  logic [M-1:0][1:0] b_osrc;
  logic [M-1:0]      b_ovalid, b_oready;

  xbar_stream_switch i_xbar_stream_switch (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(a_flush), .prio_i(a_prio),
    .in_data_i(a_data), .in_sel_i(a_sel), .in_valid_i(a_valid), .in_ready_o(a_iready),
    .out_data_o(a_odata), .out_src_o(a_osrc), .out_valid_o(a_ovalid), .out_ready_i(a_oready)
  );

  xbar_stream_switch #(.Spill(1'b1), .ExtPrio(1'b1)) i_xbar_stream_switch_sx (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(1'b0), .prio_i(b_prio),
    .in_data_i(b_data), .in_sel_i(b_sel), .in_valid_i(b_valid), .in_ready_o(b_iready),
    .out_data_o(b_odata), .out_src_o(b_osrc), .out_valid_o(b_ovalid), .out_ready_i(b_oready)
  );

  int n_chk = 0;
  int n_bad = 0;
  int ptr_m [M];
  bit lk_m  [M];
  int lki_m [M];
  logic [N-1:0] acc;
  logic [31:0]  rs = 32'h1234_5678;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  // Reference arbitration for instance A, checked then advanced per cycle.
  task automatic step_a();
    logic [N-1:0] ex_rdy, rq;
    logic [M-1:0] ex_v;
    int win [M];
    bit f;
    int c;
    #1;
    ex_rdy = '0;
    ex_v   = '0;
    for (int j = 0; j < M; j++) begin
      rq = '0;
      for (int i = 0; i < N; i++) rq[i] = a_valid[i] && (int'(a_sel[i]) == j);
      win[j] = 0;
      if (rq != 0) begin
        ex_v[j] = 1'b1;
        if (lk_m[j] && rq[lki_m[j]]) win[j] = lki_m[j];
        else begin
          f = 1'b0;
          for (int k = 0; k < N; k++) begin
            c = (ptr_m[j] + k) % N;
            if (!f && rq[c]) begin f = 1'b1; win[j] = c; end
          end
        end
        if (a_oready[j]) ex_rdy[win[j]] = 1'b1;
      end
    end
    check("R2 consumer valid", a_ovalid, ex_v);
    check("R4 producer ready", a_iready, ex_rdy);
    for (int j = 0; j < M; j++) begin
      if (ex_v[j]) begin
        check("R3 granted index", a_osrc[j], win[j]);
        check("R2 payload", a_odata[j], a_data[win[j]]);
      end
    end
    for (int j = 0; j < M; j++) begin
      if (a_flush) begin
        ptr_m[j] = 0; lk_m[j] = 1'b0;
      end else if (ex_v[j] && a_oready[j]) begin
        ptr_m[j] = (win[j] + 1) % N; lk_m[j] = 1'b0;
      end else if (ex_v[j]) begin
        lk_m[j] = 1'b1; lki_m[j] = win[j];
      end else lk_m[j] = 1'b0;
    end
    acc = a_valid & ex_rdy;
  endtask

  task automatic idle_a();
    @(negedge clk);
    a_valid = '0; a_flush = 1'b0;
    step_a();
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    a_flush = 1'b0; a_prio = '0; a_data = '0; a_sel = '0; a_valid = '0; a_oready = '0;
    b_prio = '0; b_prio[0] = 2'd2; b_data = '0; b_sel = '0; b_valid = '0; b_oready = '0;
    acc = '0;
    for (int j = 0; j < M; j++) begin ptr_m[j] = 0; lk_m[j] = 1'b0; lki_m[j] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 staged consumers empty after reset", b_ovalid, 0);

    // R1 / R3: all producers to consumer 0, grants rotate 0,1,2,3
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      a_valid  = 4'hF << k;
      a_sel    = '0;
      for (int i = 0; i < N; i++) a_data[i] = 8'h10 + 8'(i);
      a_oready = 3'b111;
      step_a();
      check("R1 R3 rotation order", a_osrc[0], k);
      check("R4 single ready", a_iready, 1 << k);
    end
    idle_a();

    // R5 / R6: lock-in against a producer nearer the pointer
    @(negedge clk);
    a_oready = 3'b000; a_valid = 4'b0100;
    step_a();
    check("R3 sole requester", a_osrc[0], 2);
    @(negedge clk);
    a_valid = 4'b0101;
    step_a();
    check("R5 grant held", a_osrc[0], 2);
    check("R6 stalled payload", a_odata[0], 8'h12);
    check("R5 no ready while stalled", a_iready, 0);
    @(negedge clk);
    a_oready = 3'b001;
    step_a();
    check("R5 held producer served", a_iready, 4'b0100);
    @(negedge clk);
    a_valid = 4'b0001;
    step_a();
    check("R3 after wrap", a_osrc[0], 0);
    idle_a();

    // R7: move pointer of consumer 1, flush, then full contention
    @(negedge clk);
    a_oready = 3'b111; a_valid = 4'b0010; a_sel = '0; a_sel[1] = 2'd1;
    step_a();
    @(negedge clk);
    a_valid = '0; a_flush = 1'b1;
    step_a();
    @(negedge clk);
    a_flush = 1'b0; a_valid = 4'hF;
    for (int i = 0; i < N; i++) a_sel[i] = 2'd1;
    step_a();
    check("R7 flush restarts at producer 0", a_osrc[1], 0);
    idle_a();

    // R2: three consumers served in one cycle
    @(negedge clk);
    a_valid = 4'b1011; a_sel[0] = 2'd2; a_sel[1] = 2'd1; a_sel[3] = 2'd0;
    step_a();
    check("R2 parallel readies", a_iready, 4'b1011);
    check("R2 consumer 0 source", a_osrc[0], 3);
    check("R2 consumer 2 payload", a_odata[2], 8'h10);
    idle_a();

    // R10: out-of-range select
    @(negedge clk);
    a_valid = 4'b0010; a_sel[1] = 2'd3;
    step_a();
    check("R10 bad select no consumer", a_ovalid, 0);
    check("R10 bad select no ready", a_iready, 0);
    idle_a();

    // R2 R3 R4 R5: pseudo-random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        if (!(a_valid[i] && !acc[i])) begin
          rs = nxt(rs);
          a_valid[i] = rs[0] | rs[1];
          a_sel[i]   = 2'(rs[9:8] % 2'd3);
          a_data[i]  = rs[23:16];
        end
      end
      rs = nxt(rs);
      a_oready = rs[2:0] | rs[5:3];
      step_a();
    end
    idle_a();

    // R8 / R9: staged build with external start index 2 on consumer 0
    @(negedge clk);
    b_valid = 4'hF; b_sel = '0;
    for (int i = 0; i < N; i++) b_data[i] = 8'h50 + 8'(i);
    b_data[2] = 8'hA0; b_oready = '0;
    #1;
    check("R9 no same-cycle output", b_ovalid[0], 0);
    check("R8 search starts at 2", b_iready, 4'b0100);
    @(negedge clk);
    b_data[2] = 8'hA1;
    #1;
    check("R9 one cycle latency", b_ovalid[0], 1);
    check("R9 first item", b_odata[0], 8'hA0);
    check("R9 ready ignores stall", b_iready, 4'b0100);
    @(negedge clk);
    b_data[2] = 8'hA2;
    #1;
    check("R9 full after two", b_iready, 0);
    check("R9 oldest shown", b_odata[0], 8'hA0);
    @(negedge clk);
    b_oready = 3'b001;
    #1;
    check("R9 ready from occupancy", b_iready, 0);
    check("R9 oldest until taken", b_odata[0], 8'hA0);
    @(negedge clk);
    #1;
    check("R9 second item", b_odata[0], 8'hA1);
    check("R8 start point fixed", b_iready, 4'b0100);
    @(negedge clk);
    b_valid = '0;
    #1;
    check("R9 third item", b_odata[0], 8'hA2);
    check("R8 source index", b_osrc[0], 2);
    @(negedge clk);
    #1;
    check("R9 drained", b_ovalid[0], 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule